// File: doc/BRIEF.md
# Filtered Timer Input Edge Detector

This block turns a raw timer input pin into a one-cycle strobe that marks a valid edge. The pin is first brought into the system clock domain, then passed through a noise filter that only accepts a new level after it has been seen identically on two successive sampling ticks. The strobe fires on rising edges, falling edges or both, depending on a two-bit select.

The sampling tick depends on what the pin is used for. When the pin feeds the timer's count clock, the tick is a fixed divide-by-8 of the system clock. When the pin is a capture trigger, the tick is a pulse from an external prescaler. The filter holds its accepted level across a stop and restart of the timer. As a result, a pin that is already high when the timer starts for the first time after reset produces one rising edge. A pin that is high at a later restart produces none.

Top module: `tin_edge_detect`

## Requirements
- R1: While reset is asserted and after it is released, the strobe is low and the accepted (filtered) level is 0.
- R2: The pin passes through a two-flop synchronizer before the filter. A pin change cannot affect the strobe sooner than three clock edges later.
- R3: A new level is accepted only when the synchronized pin reads the same value on two successive sampling ticks. A pulse seen on just one tick is rejected.
- R4: With `src_sel_i` = 0 (count-clock use), a sampling tick occurs once every 8 system clocks. The tick comes from a free-running counter that starts at 0 on reset and ticks when it reaches 7.
- R5: With `src_sel_i` = 1 (capture use), a sampling tick occurs in each cycle where `presc_tick_i` is high.
- R6: The edge select `edge_sel_i` works as follows: 2'b01 gives rising edges only, 2'b10 falling edges only, 2'b11 both edges, and 2'b00 no edges.
- R7: The strobe is high for exactly one system clock per accepted level change. It goes high in the cycle after the clock edge on which the level is accepted.
- R8: While `run_i` is low, the strobe is low and the filter and accepted level are frozen. Sampling ticks are ignored.
- R9: The accepted level keeps its value across a stop and restart. A pin that is high at restart, with the level already 1, gives no strobe.
- R10: If the pin is high after reset and rising or both edges are selected, a rising strobe appears once `run_i` is raised, after the filter has taken two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw timer input pin |
| edge_sel_i | input | 2 | Valid-edge select (01 rise, 10 fall, 11 both, 00 none) |
| src_sel_i | input | 1 | Sampling source: 0 divide-by-8, 1 prescaler tick |
| run_i | input | 1 | Timer run enable |
| presc_tick_i | input | 1 | Prescaler tick, one clock wide |
| edge_o | output | 1 | Valid-edge strobe |

## Verification
The assertions assume that `edge_sel_i` and `src_sel_i` change only while `run_i` is low. They also assume that `presc_tick_i` is a single-cycle pulse, so a strobe relates to the select that was in force when its level was accepted. The bench keeps to these assumptions: it changes the configuration only during stopped intervals, and it drives the prescaler tick as a one-cycle pulse every fifth clock. Pin widths swept from one clock to forty clocks straddle the filter window in both sampling modes.

// File: rtl/tin_edge_pkg.sv
package tin_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_t;

  typedef enum logic {
    SRC_DIV   = 1'b0,
    SRC_PRESC = 1'b1
  } samp_src_t;

endpackage

// File: rtl/tin_pin_sync.sv
module tin_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tin_samp_tick.sv
module tin_samp_tick
  import tin_edge_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  samp_src_t src_i,
  input  logic      presc_tick_i,
  output logic      tick_o
);
  localparam logic [DIV_W-1:0] DivLast = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             div_tick;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign div_tick = (div_q == DivLast);

  always_comb begin
    case (src_i)
      SRC_PRESC: tick_o = presc_tick_i;
      default:   tick_o = div_tick;
    endcase
  end
endmodule

// File: rtl/tin_level_filter.sv
module tin_level_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_en_i,
  input  logic d_i,
  output logic accept_o,
  output logic new_lvl_o,
  output logic lvl_o
);
  logic samp_q, samp_d;
  logic lvl_q,  lvl_d;
  logic agree;

  always_comb begin
    agree     = (d_i == samp_q);
    accept_o  = samp_en_i && agree && (d_i != lvl_q);
    new_lvl_o = d_i;
    samp_d    = samp_q;
    lvl_d     = lvl_q;
    if (samp_en_i) begin
      samp_d = d_i;
      if (agree) lvl_d = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R3 R8
  lvl_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(samp_en_i));
endmodule

// File: rtl/tin_edge_qual.sv
module tin_edge_qual
  import tin_edge_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  edge_sel_t sel_i,
  input  logic      accept_i,
  input  logic      new_lvl_i,
  input  logic      lvl_i,
  output logic      strobe_o
);
  logic want;
  logic strobe_q, strobe_d;

  always_comb begin
    case (sel_i)
      EDGE_RISE: want = new_lvl_i;
      EDGE_FALL: want = !new_lvl_i;
      EDGE_BOTH: want = 1'b1;
      default:   want = 1'b0;
    endcase
    strobe_d = accept_i && want;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  // R6
  rise_sel_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && sel_i == EDGE_RISE) |-> lvl_i);
  // R6
  fall_sel_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && sel_i == EDGE_FALL) |-> !lvl_i);
endmodule

// File: rtl/tin_edge_detect.sv
module tin_edge_detect
  import tin_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  input  logic       src_sel_i,
  input  logic       run_i,
  input  logic       presc_tick_i,
  output logic       edge_o
);
  logic pin_s;
  logic tick;
  logic samp_en;
  logic accept, new_lvl, lvl;
  logic strobe;

  tin_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  tin_samp_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (samp_src_t'(src_sel_i)),
    .presc_tick_i(presc_tick_i),
    .tick_o      (tick)
  );

  assign samp_en = run_i && tick;

  tin_level_filter u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .samp_en_i(samp_en),
    .d_i      (pin_s),
    .accept_o (accept),
    .new_lvl_o(new_lvl),
    .lvl_o    (lvl)
  );

  tin_edge_qual u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (edge_sel_t'(edge_sel_i)),
    .accept_i (accept),
    .new_lvl_i(new_lvl),
    .lvl_i    (lvl),
    .strobe_o (strobe)
  );

  assign edge_o = strobe && run_i;

  // R7
  one_cycle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
  // R8
  quiet_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !edge_o);
endmodule

// File: tb/test_tin_edge_detect.sv
module test_tin_edge_detect;
  logic clk = 1'b0;
  logic rst_n, pin, run, src, presc;
  logic [1:0] sel;
  logic edge_o;
  int vectors = 0, fails = 0, pc = 0, strobes = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  tin_edge_detect i_tin_edge_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .edge_sel_i(sel),
    .src_sel_i(src), .run_i(run), .presc_tick_i(presc), .edge_o(edge_o)
  );

  // reference model built from the requirements
  logic [1:0] m_pipe;   // R2 two-stage input delay
  logic [2:0] m_phase;  // R4 clocks since reset mod 8
  logic m_last, m_lvl, m_str;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe <= 0; m_phase <= 0; m_last <= 0; m_lvl <= 0; m_str <= 0;
    end else begin
      automatic bit t = run && (src ? presc : (m_phase == 3'd7));
      automatic bit v = m_pipe[1];
      automatic bit chg = t && (v == m_last) && (v != m_lvl);
      m_pipe  <= {m_pipe[0], pin};
      m_phase <= m_phase + 3'd1;
      if (t) m_last <= v;
      if (chg) m_lvl <= v;
      m_str <= chg && ((sel == 2'b11) || (sel == 2'b01 && v) || (sel == 2'b10 && !v));
    end
  end

  task automatic cyc();
    @(negedge clk);
    vectors++;
    if (edge_o !== (m_str && run)) begin
      fails++;
      $display("FAIL %s: edge_o=%0b expected %0b at %0t", cur_req, edge_o, m_str && run, $time);
    end
    if (edge_o === 1'b1) strobes++;
    pc = (pc == 4) ? 0 : pc + 1;
    presc = (pc == 4);
  endtask

  task automatic check_count(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: strobe count=%0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] lf = 8'h5a;
    int widths[6] = '{1, 3, 9, 17, 25, 40};
    rst_n = 0; pin = 1; run = 0; src = 0; sel = 2'b01; presc = 0;
    repeat (4) @(negedge clk);
    cur_req = "R1 reset";
    check_count("R1", int'(edge_o), 0);
    rst_n = 1;
    repeat (6) cyc();
    check_count("R1 idle after reset", strobes, 0);
    // R10: pin already high, rising selected, first start
    cur_req = "R10 first start";
    strobes = 0; run = 1;
    repeat (40) cyc();
    check_count("R10", strobes, 1);
    // R9: stop and restart with pin high
    cur_req = "R9 restart";
    run = 0; repeat (12) cyc();
    strobes = 0; run = 1; repeat (40) cyc();
    check_count("R9", strobes, 0);
    // R8: pin toggles while stopped, no strobe and level frozen
    cur_req = "R8 stopped";
    run = 0; strobes = 0;
    for (int i = 0; i < 6; i++) begin pin = ~pin; repeat (20) cyc(); end
    check_count("R8", strobes, 0);
    run = 1; repeat (40) cyc();
    check_count("R8 level held across stop", strobes, 0);
    // sweep over sources and edge selects
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        run = 0; repeat (3) cyc();
        src = m[0]; sel = s[1:0];
        cur_req = m ? "R5 R3 R6 R7 R2 capture sweep" : "R4 R3 R6 R7 R2 count sweep";
        run = 1; strobes = 0;
        for (int k = 0; k < 40; k++) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          pin = ~pin;
          repeat (widths[lf % 6]) cyc();
        end
        if (s == 0) check_count("R6 none selected", strobes, 0);
        else begin
          vectors++;
          if (strobes == 0) begin
            fails++;
            $display("FAIL R6: strobe count=0 expected >0 for sel=%0d", s);
          end
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule